// File: doc/BRIEF.md
# Two-Dimensional Parity Codec

This block protects a 16-bit payload by laying it out as a 4x4 bit grid and attaching one even-parity bit per row, one per column, and a corner bit. The encoder path turns a data word into a 25-bit codeword. The decoder path takes a received 25-bit word and recomputes every row and column check. It repairs a single flipped payload bit at the crossing of the failing row and the failing column, and reports any two-bit damage as detected but not repairable.

Each path registers its result. An output valid follows the matching input valid exactly one clock later. The encoder and decoder are independent, so a link can use one side or both in the same cycle.

In the codeword, bit `r*4+c` carries the payload bit of row `r`, column `c`. Rows and columns count from 0, so bit 0 is the first bit of the first row. Bits 16..19 carry the row checks for rows 0..3. Bits 20..23 carry the column checks for columns 0..3. Bit 24 is the corner bit. The payload word uses the same index as the low 16 codeword bits.

Top module: `tdp_codec`

## Requirements
- R1: For every encoded word, codeword bit 16+r equals the XOR of payload bits r*4..r*4+3, so each row together with its check bit holds an even number of ones.
- R2: For every encoded word, codeword bit 20+c equals the XOR of payload bits c, 4+c, 8+c and 12+c, so each column together with its check bit holds an even number of ones.
- R3: Codeword bit 24 equals the XOR of bits 16..19, which is also the XOR of bits 20..23.
- R4: `enc_valid_o` rises exactly one cycle after a cycle with `enc_valid_i` high, with codeword bits 15..0 equal to the payload presented. A cycle with `enc_valid_i` low produces `enc_valid_o` low and a zero codeword one cycle later.
- R5: When every row and column check of a received word passes, `dec_data_o` equals received bits 15..0 and `dec_clean_o` is set. This holds whatever the corner bit is.
- R6: When exactly one payload bit of a valid codeword is flipped, `dec_data_o` equals the original payload and `dec_fixed_o` is set.
- R7: When exactly one row-check or column-check bit is flipped, `dec_data_o` equals received bits 15..0 and `dec_fixed_o` is set.
- R8: When any two distinct bits of a valid codeword are flipped, `dec_fail_o` is set and `dec_data_o` equals received bits 15..0, with no repair attempted.
- R9: With `dec_valid_o` high, exactly one of `dec_clean_o`, `dec_fixed_o` and `dec_fail_o` is set. With `dec_valid_o` low, all three flags and `dec_data_o` are zero.
- R10: `dec_valid_o` and the decoder result appear exactly one cycle after the cycle with `dec_valid_i` high. Back-to-back inputs give back-to-back results.
- R11: While `rst_i` is high at a clock edge, every output is zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| enc_valid_i | input | 1 | Payload on `enc_data_i` is to be encoded |
| enc_data_i | input | 16 | Payload to encode, index r*4+c |
| enc_valid_o | output | 1 | Codeword on `enc_code_o` is valid |
| enc_code_o | output | 25 | Encoded word: payload, row checks, column checks, corner |
| dec_valid_i | input | 1 | Word on `dec_code_i` is to be decoded |
| dec_code_i | input | 25 | Received word in codeword layout |
| dec_valid_o | output | 1 | Decoder result valid |
| dec_data_o | output | 16 | Repaired or passed-through payload |
| dec_clean_o | output | 1 | All row and column checks passed |
| dec_fixed_o | output | 1 | Single error found and handled |
| dec_fail_o | output | 1 | Error detected that cannot be repaired |

## Verification
The decoder holds no state across words, so an internal fault shows up at the ports one cycle after the word that exposes it. A wrong row or column syndrome either flips a payload bit at the wrong crossing or drops a word into the wrong status class. Either error is visible in that same output cycle. For this reason the bench sweeps every single-bit position and every pair of positions.

On the encoder side, a miswired check bit corrupts one named codeword field. The bench compares the row, column and corner fields on their own against sums computed from the requirements.

// File: rtl/tdp_pkg.sv
`timescale 1ns/1ps
package tdp_pkg;

    localparam int unsigned GRID_ROWS = 4;
    localparam int unsigned GRID_COLS = 4;

    typedef enum logic [1:0] {
        CLS_CLEAN = 2'd0,
        CLS_FIXED = 2'd1,
        CLS_FAIL  = 2'd2
    } cls_e;

endpackage

// File: rtl/tdp_parity_gen.sv
`timescale 1ns/1ps
module tdp_parity_gen #(
    parameter int unsigned ROWS = tdp_pkg::GRID_ROWS,
    parameter int unsigned COLS = tdp_pkg::GRID_COLS,
    localparam int unsigned DW  = ROWS * COLS
) (
    input  logic [DW-1:0]   data_i,
    output logic [ROWS-1:0] row_par_o,
    output logic [COLS-1:0] col_par_o
);

    // one even-parity bit per row: row bits are contiguous
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_par_o[r] = ^data_i[r*COLS +: COLS];
    end

    // one even-parity bit per column: gather strided bits first
    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic [ROWS-1:0] col_bits;
        for (genvar r = 0; r < ROWS; r++) begin : g_tap
            assign col_bits[r] = data_i[r*COLS + c];
        end
        assign col_par_o[c] = ^col_bits;
    end

endmodule

// File: rtl/tdp_enc_core.sv
`timescale 1ns/1ps
module tdp_enc_core #(
    parameter int unsigned ROWS = tdp_pkg::GRID_ROWS,
    parameter int unsigned COLS = tdp_pkg::GRID_COLS,
    localparam int unsigned DW  = ROWS * COLS,
    localparam int unsigned CW  = DW + ROWS + COLS + 1
) (
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] code_o
);

    logic [ROWS-1:0] row_par;
    logic [COLS-1:0] col_par;

    tdp_parity_gen #(.ROWS(ROWS), .COLS(COLS)) u_gen (
        .data_i    (data_i),
        .row_par_o (row_par),
        .col_par_o (col_par)
    );

    // layout, low to high: payload, row checks, column checks, corner
    assign code_o = {^row_par, col_par, row_par, data_i};

endmodule

// File: rtl/tdp_dec_core.sv
`timescale 1ns/1ps
module tdp_dec_core #(
    parameter int unsigned ROWS = tdp_pkg::GRID_ROWS,
    parameter int unsigned COLS = tdp_pkg::GRID_COLS,
    localparam int unsigned DW  = ROWS * COLS,
    localparam int unsigned CW  = DW + ROWS + COLS + 1
) (
    input  logic [CW-1:0]   code_i,
    output logic [DW-1:0]   data_o,
    output tdp_pkg::cls_e   cls_o
);
    import tdp_pkg::*;

    logic [DW-1:0]   rx_data;
    logic [ROWS-1:0] rx_row;
    logic [COLS-1:0] rx_col;
    logic [ROWS-1:0] calc_row;
    logic [COLS-1:0] calc_col;
    logic [ROWS-1:0] row_syn;
    logic [COLS-1:0] col_syn;
    logic            odd_total;
    logic            one_row;
    logic            one_col;
    logic            max_one_row;
    logic            max_one_col;
    logic            hit_data;
    logic [DW-1:0]   fix_mask;

    assign rx_data = code_i[DW-1:0];
    assign rx_row  = code_i[DW +: ROWS];
    assign rx_col  = code_i[DW+ROWS +: COLS];

    tdp_parity_gen #(.ROWS(ROWS), .COLS(COLS)) u_gen (
        .data_i    (rx_data),
        .row_par_o (calc_row),
        .col_par_o (calc_col)
    );

    assign row_syn = calc_row ^ rx_row;
    assign col_syn = calc_col ^ rx_col;

    // a valid codeword has an even total weight; one flip makes it odd
    assign odd_total   = ^code_i;
    assign one_row     = ($countones(row_syn) == 1);
    assign one_col     = ($countones(col_syn) == 1);
    assign max_one_row = ($countones(row_syn) <= 1);
    assign max_one_col = ($countones(col_syn) <= 1);
    assign hit_data    = odd_total && one_row && one_col;

    // repair mask: the crossing of the single failing row and column
    for (genvar r = 0; r < ROWS; r++) begin : g_fr
        for (genvar c = 0; c < COLS; c++) begin : g_fc
            assign fix_mask[r*COLS + c] = hit_data & row_syn[r] & col_syn[c];
        end
    end

    assign data_o = rx_data ^ fix_mask;

    always_comb begin
        if ((row_syn == '0) && (col_syn == '0)) begin
            cls_o = CLS_CLEAN;
        end else if (odd_total && max_one_row && max_one_col) begin
            cls_o = CLS_FIXED;
        end else begin
            cls_o = CLS_FAIL;
        end
    end

endmodule

// File: rtl/tdp_codec.sv
`timescale 1ns/1ps
module tdp_codec #(
    parameter int unsigned ROWS = tdp_pkg::GRID_ROWS,
    parameter int unsigned COLS = tdp_pkg::GRID_COLS,
    localparam int unsigned DW  = ROWS * COLS,
    localparam int unsigned CW  = DW + ROWS + COLS + 1
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          enc_valid_i,
    input  logic [DW-1:0] enc_data_i,
    output logic          enc_valid_o,
    output logic [CW-1:0] enc_code_o,
    input  logic          dec_valid_i,
    input  logic [CW-1:0] dec_code_i,
    output logic          dec_valid_o,
    output logic [DW-1:0] dec_data_o,
    output logic          dec_clean_o,
    output logic          dec_fixed_o,
    output logic          dec_fail_o
);
    import tdp_pkg::*;

    typedef struct packed {
        logic          enc_v;
        logic [CW-1:0] enc_code;
        logic          dec_v;
        logic [DW-1:0] dec_data;
        logic          clean;
        logic          fixed;
        logic          fail;
    } state_t;

    state_t        st_d, st_q;
    logic [CW-1:0] enc_word;
    logic [DW-1:0] dec_word;
    cls_e          dec_cls;

    tdp_enc_core #(.ROWS(ROWS), .COLS(COLS)) u_enc (
        .data_i (enc_data_i),
        .code_o (enc_word)
    );

    tdp_dec_core #(.ROWS(ROWS), .COLS(COLS)) u_dec (
        .code_i (dec_code_i),
        .data_o (dec_word),
        .cls_o  (dec_cls)
    );

    always_comb begin
        st_d = '0;
        if (enc_valid_i) begin
            st_d.enc_v    = 1'b1;
            st_d.enc_code = enc_word;
        end
        if (dec_valid_i) begin
            st_d.dec_v    = 1'b1;
            st_d.dec_data = dec_word;
            st_d.clean    = (dec_cls == CLS_CLEAN);
            st_d.fixed    = (dec_cls == CLS_FIXED);
            st_d.fail     = (dec_cls == CLS_FAIL);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enc_valid_o = st_q.enc_v;
    assign enc_code_o  = st_q.enc_code;
    assign dec_valid_o = st_q.dec_v;
    assign dec_data_o  = st_q.dec_data;
    assign dec_clean_o = st_q.clean;
    assign dec_fixed_o = st_q.fixed;
    assign dec_fail_o  = st_q.fail;

endmodule

// File: rtl/tdp_codec_chk.sv
`timescale 1ns/1ps
module tdp_codec_chk #(
    parameter int unsigned ROWS = tdp_pkg::GRID_ROWS,
    parameter int unsigned COLS = tdp_pkg::GRID_COLS,
    localparam int unsigned DW  = ROWS * COLS,
    localparam int unsigned CW  = DW + ROWS + COLS + 1
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          enc_valid_i,
    input logic [DW-1:0] enc_data_i,
    input logic          enc_valid_o,
    input logic [CW-1:0] enc_code_o,
    input logic          dec_valid_i,
    input logic [CW-1:0] dec_code_i,
    input logic          dec_valid_o,
    input logic [DW-1:0] dec_data_o,
    input logic          dec_clean_o,
    input logic          dec_fixed_o,
    input logic          dec_fail_o
);

    p_enc_even_total_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        enc_valid_o |-> (^enc_code_o) == 1'b0);

    p_enc_corner_cols_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        enc_valid_o |-> enc_code_o[CW-1] == ^enc_code_o[CW-2 -: COLS]);

    p_enc_latency_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        enc_valid_i |=> enc_valid_o);

    p_enc_idle_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !enc_valid_i |=> !enc_valid_o);

    p_enc_payload_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        enc_valid_i |=> enc_code_o[DW-1:0] == $past(enc_data_i));

    p_clean_pass_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (dec_valid_o && dec_clean_o) |-> dec_data_o == $past(dec_code_i[DW-1:0]));

    p_fail_pass_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (dec_valid_o && dec_fail_o) |-> dec_data_o == $past(dec_code_i[DW-1:0]));

    p_one_flag_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        dec_valid_o |-> $countones({dec_clean_o, dec_fixed_o, dec_fail_o}) == 1);

    p_quiet_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !dec_valid_o |-> ({dec_clean_o, dec_fixed_o, dec_fail_o} == 3'b000 && dec_data_o == '0));

    p_dec_latency_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        dec_valid_i |=> dec_valid_o);

endmodule

bind tdp_codec tdp_codec_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (.*);

// File: tb/tb_tdp_codec.sv
`timescale 1ns/1ps
module tb_tdp_codec;

    localparam int DW = 16;
    localparam int CW = 25;

    logic          clk_i = 1'b0;
    logic          rst_i = 1'b1;
    logic          enc_valid_i = 1'b0;
    logic [DW-1:0] enc_data_i = '0;
    logic          enc_valid_o;
    logic [CW-1:0] enc_code_o;
    logic          dec_valid_i = 1'b0;
    logic [CW-1:0] dec_code_i = '0;
    logic          dec_valid_o;
    logic [DW-1:0] dec_data_o;
    logic          dec_clean_o;
    logic          dec_fixed_o;
    logic          dec_fail_o;

    int n_chk = 0;
    int n_err = 0;

    localparam logic [2:0] F_CLEAN = 3'b100;
    localparam logic [2:0] F_FIXED = 3'b010;
    localparam logic [2:0] F_FAIL  = 3'b001;

    always #2.5 clk_i = ~clk_i;

    tdp_codec dut (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .enc_valid_i (enc_valid_i),
        .enc_data_i  (enc_data_i),
        .enc_valid_o (enc_valid_o),
        .enc_code_o  (enc_code_o),
        .dec_valid_i (dec_valid_i),
        .dec_code_i  (dec_code_i),
        .dec_valid_o (dec_valid_o),
        .dec_data_o  (dec_data_o),
        .dec_clean_o (dec_clean_o),
        .dec_fixed_o (dec_fixed_o),
        .dec_fail_o  (dec_fail_o)
    );

    // reference encoder built from R1..R3 and the codeword layout
    function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d);
        logic [CW-1:0] w;
        w = '0;
        w[DW-1:0] = d;
        for (int r = 0; r < 4; r++) w[16+r] = ^d[r*4 +: 4];
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) w[20+c] = w[20+c] ^ d[r*4+c];
        w[24] = ^w[19:16];
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic enc_one(input logic [DW-1:0] d);
        logic [CW-1:0] e;
        e = ref_enc(d);
        @(negedge clk_i);
        enc_valid_i = 1'b1;
        enc_data_i  = d;
        @(posedge clk_i);
        #1;
        enc_valid_i = 1'b0;
        chk(enc_valid_o == 1'b1, "R4 enc valid", 32'(enc_valid_o), 32'd1);
        chk(enc_code_o[15:0] == d, "R4 payload bits", 32'(enc_code_o[15:0]), 32'(d));
        chk(enc_code_o[19:16] == e[19:16], "R1 row checks", 32'(enc_code_o[19:16]), 32'(e[19:16]));
        chk(enc_code_o[23:20] == e[23:20], "R2 column checks", 32'(enc_code_o[23:20]), 32'(e[23:20]));
        chk(enc_code_o[24] == e[24], "R3 corner", 32'(enc_code_o[24]), 32'(e[24]));
    endtask

    task automatic dec_one(input logic [CW-1:0] w, input logic [DW-1:0] exp_d,
                           input logic [2:0] exp_f, input string tag);
        @(negedge clk_i);
        dec_valid_i = 1'b1;
        dec_code_i  = w;
        @(posedge clk_i);
        #1;
        dec_valid_i = 1'b0;
        chk(dec_valid_o == 1'b1, {tag, " R10 dec valid"}, 32'(dec_valid_o), 32'd1);
        chk(dec_data_o == exp_d, {tag, " data"}, 32'(dec_data_o), 32'(exp_d));
        chk({dec_clean_o, dec_fixed_o, dec_fail_o} == exp_f, {tag, " R9 flags"},
            32'({dec_clean_o, dec_fixed_o, dec_fail_o}), 32'(exp_f));
    endtask

    task automatic t_reset;
        @(negedge clk_i);
        rst_i = 1'b1;
        enc_valid_i = 1'b1;
        enc_data_i  = 16'hA5C3;
        dec_valid_i = 1'b1;
        dec_code_i  = 25'h1FFFFFF;
        repeat (2) @(posedge clk_i);
        #1;
        chk({enc_valid_o, dec_valid_o} == 2'b00, "R11 valids in reset",
            32'({enc_valid_o, dec_valid_o}), 32'd0);
        chk(enc_code_o == '0, "R11 codeword in reset", 32'(enc_code_o), 32'd0);
        chk({dec_data_o, dec_clean_o, dec_fixed_o, dec_fail_o} == '0, "R11 decoder in reset",
            32'({dec_data_o, dec_clean_o, dec_fixed_o, dec_fail_o}), 32'd0);
        @(negedge clk_i);
        rst_i = 1'b0;
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
    endtask

    task automatic t_encode;
        enc_one(16'h0000);
        chk(enc_code_o == 25'h0000000, "R1 R2 R3 zero word", 32'(enc_code_o), 32'h0);
        enc_one(16'hFFFF);
        chk(enc_code_o == 25'h000FFFF, "R1 R2 R3 all ones", 32'(enc_code_o), 32'h000FFFF);
        enc_one(16'h0001);
        chk(enc_code_o == 25'h1110001, "R1 R2 R3 single one", 32'(enc_code_o), 32'h1110001);
        enc_one(16'h6C55);
        enc_one(16'h8421);
        enc_one(16'h1357);
    endtask

    task automatic t_enc_idle;
        @(negedge clk_i);
        enc_valid_i = 1'b0;
        enc_data_i  = 16'hBEEF;
        @(posedge clk_i);
        #1;
        chk(enc_valid_o == 1'b0 && enc_code_o == '0, "R4 idle encoder",
            32'({enc_valid_o, enc_code_o}), 32'd0);
    endtask

    task automatic t_clean;
        dec_one(ref_enc(16'h0000), 16'h0000, F_CLEAN, "R5 zero");
        dec_one(ref_enc(16'h6C55), 16'h6C55, F_CLEAN, "R5 pattern a");
        dec_one(ref_enc(16'hF00F), 16'hF00F, F_CLEAN, "R5 pattern b");
        dec_one(ref_enc(16'h6C55) ^ (25'd1 << 24), 16'h6C55, F_CLEAN, "R5 corner flipped");
    endtask

    task automatic t_single_data;
        logic [CW-1:0] w;
        w = ref_enc(16'h3A96);
        for (int i = 0; i < 16; i++)
            dec_one(w ^ (25'd1 << i), 16'h3A96, F_FIXED, $sformatf("R6 bit %0d", i));
    endtask

    task automatic t_single_par;
        logic [CW-1:0] w;
        w = ref_enc(16'hC1E4);
        for (int i = 16; i < 24; i++)
            dec_one(w ^ (25'd1 << i), 16'hC1E4, F_FIXED, $sformatf("R7 bit %0d", i));
    endtask

    task automatic t_double;
        logic [CW-1:0] w;
        logic [CW-1:0] bad;
        w = ref_enc(16'h5B2D);
        for (int i = 0; i < CW; i++) begin
            for (int j = i + 1; j < CW; j++) begin
                bad = w ^ (25'd1 << i) ^ (25'd1 << j);
                dec_one(bad, bad[15:0], F_FAIL, $sformatf("R8 bits %0d,%0d", i, j));
            end
        end
    endtask

    task automatic t_dec_idle;
        dec_one(ref_enc(16'h1234) ^ 25'd4, 16'h1234, F_FIXED, "R9 before idle");
        @(negedge clk_i);
        dec_valid_i = 1'b0;
        dec_code_i  = 25'h0ABCDEF;
        @(posedge clk_i);
        #1;
        chk(dec_valid_o == 1'b0 && dec_data_o == '0 &&
            {dec_clean_o, dec_fixed_o, dec_fail_o} == 3'b000, "R9 idle decoder",
            32'({dec_valid_o, dec_data_o, dec_clean_o, dec_fixed_o, dec_fail_o}), 32'd0);
    endtask

    task automatic t_back2back;
        logic [CW-1:0] a;
        logic [CW-1:0] b;
        a = ref_enc(16'h00FF);
        b = ref_enc(16'hFF00) ^ (25'd1 << 9);
        @(negedge clk_i);
        dec_valid_i = 1'b1;
        dec_code_i  = a;
        @(posedge clk_i);
        #1;
        dec_code_i = b;
        chk(dec_valid_o && dec_data_o == 16'h00FF && dec_clean_o, "R10 first of pair",
            32'({dec_valid_o, dec_data_o}), 32'h100FF);
        @(posedge clk_i);
        #1;
        dec_valid_i = 1'b0;
        chk(dec_valid_o && dec_data_o == 16'hFF00 && dec_fixed_o, "R10 second of pair",
            32'({dec_valid_o, dec_data_o}), 32'h1FF00);
        @(posedge clk_i);
        #1;
        chk(dec_valid_o == 1'b0, "R10 valid drops", 32'(dec_valid_o), 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_encode();
        t_enc_idle();
        t_clean();
        t_single_data();
        t_single_par();
        t_double();
        t_dec_idle();
        t_back2back();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule